// File: doc/BRIEF.md
# Glitch-Free Clock Stop Controller

This block switches a set of derived clock outputs on and off in response to two active-low stop requests, without ever producing a shortened high pulse. There are two gating groups. The host group has one gated host clock, and its free-running host clock is never stopped. The bus group has a parameterised set of gated bus clocks (five by default), and its free-running bus clock is never stopped. The clock sources enter as plain level inputs. They are ideal divided clocks, sampled by one fast system clock, and every output is a registered copy of its source, one system-clock cycle late.

The stop levels pass through a two-stage synchronizer. The synchronizer advances only when the free-running bus clock rises. A change in the wanted gating state then waits for a further rising edge of the free-running bus clock. After that it waits for a falling edge of the clock being gated. Only then is the enable updated, so the enable changes only while the target clock is low. A request that goes away before the handshake completes is discarded, and the output keeps its current state.

Top module: `clkstop_ctrl`

## Requirements
- R1: When the host stop input is low (asserted), the gated host output is held at 0. When it is high, the gated host output equals the free host output. In the same way, the bus stop input holds all gated bus outputs at 0 when low, or lets each one equal the free bus output when high. The two groups are independent in all four input combinations.
- R2: The free host and free bus outputs follow their sources one system-clock cycle late, and they keep toggling in every combination of the stop inputs.
- R3: Every high pulse on a gated output starts and ends in the same cycles as the high pulse of its free counterpart. No gated high pulse is ever shortened.
- R4: A gating enable changes only after the free bus clock rises and the target clock then falls. The enable is updated only in a cycle where the target source is sampled low. Counted at the outputs from the moment a stop level is applied just after a bus rise, exactly 3 free-bus rising edges are seen before the first host pulse is suppressed or restored.
- R5: Each stop input is captured by a two-stage synchronizer that advances only on rising edges of the free bus clock. A stop level seen at only one such edge is dropped, and the gated outputs keep running with no missing pulse.
- R6: While the synchronous active-high reset is asserted, all outputs are 0 and both enables are off. After reset, with both stop inputs high, the gated outputs start through the same handshake.
- R7: A stop-input level held steady takes full effect within 60 system-clock cycles when the bus clock period is 12 system-clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock that samples every source |
| rst | input | 1 | Synchronous active-high reset |
| host_src_i | input | 1 | Host clock source level |
| bus_src_i | input | 1 | Bus clock source level |
| host_stop_n_i | input | 1 | Active-low stop request for the host group |
| bus_stop_n_i | input | 1 | Active-low stop request for the bus group |
| host_run_o | output | 1 | Free-running host clock |
| host_gate_o | output | 1 | Gated host clock |
| bus_run_o | output | 1 | Free-running bus clock |
| bus_gate_o | output | N_BUS | Gated bus clocks |

## Verification
The hardest case to reach is a request that the handshake drops. The synchronized request has to be present at exactly one bus rising edge, so that the group is armed and then released before the target clock falls. The stimulus gets there by waiting for a rising edge of the bus source and driving the stop level a nanosecond later. It then releases the stop level a nanosecond after the next rising edge. This places exactly one sampled low level in the synchronizer. The same edge-aligned timing is used to count the free-bus rising edges that occur before the first suppressed pulse and before the first restored pulse. Throughout the run, a pulse-width monitor checks every gated high pulse.

// File: rtl/clkstop_pkg.sv
package clkstop_pkg;

    localparam int N_GRP    = 2;
    localparam int GRP_HOST = 0;
    localparam int GRP_BUS  = 1;

    typedef enum logic {
        GS_IDLE  = 1'b0,
        GS_ARMED = 1'b1
    } gate_state_e;

    typedef struct packed {
        logic rise;
        logic fall;
        logic lvl;
    } edge_t;

    function automatic logic needs_change(input logic want_run, input logic en);
        return want_run != en;
    endfunction

endpackage

// File: rtl/clkstop_edge.sv
module clkstop_edge
    import clkstop_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  src_i,
    output edge_t ev_o
);
    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= src_i;
    end

    always_comb begin
        ev_o.rise = src_i & ~prev_q;
        ev_o.fall = ~src_i & prev_q;
        ev_o.lvl  = src_i;
    end
endmodule

// File: rtl/clkstop_sync.sv
module clkstop_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic adv_i,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] sh_q;

    always_ff @(posedge clk) begin
        if (rst)        sh_q <= {STAGES{RST_VAL}};
        else if (adv_i) sh_q <= {sh_q[STAGES-2:0], d_i};
    end

    assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/clkstop_gate_ctl.sv
module clkstop_gate_ctl
    import clkstop_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  want_run_i,
    input  logic  arm_i,
    input  edge_t tgt_i,
    output logic  en_o
);
    gate_state_e state_q, state_d;
    logic        en_q, en_d;

    always_comb begin
        state_d = state_q;
        en_d    = en_q;
        case (state_q)
            GS_IDLE: begin
                if (arm_i && needs_change(want_run_i, en_q)) state_d = GS_ARMED;
            end
            GS_ARMED: begin
                if (!needs_change(want_run_i, en_q)) begin
                    state_d = GS_IDLE;
                end else if (tgt_i.fall) begin
                    en_d    = want_run_i;
                    state_d = GS_IDLE;
                end
            end
            default: state_d = GS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= GS_IDLE;
            en_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            en_q    <= en_d;
        end
    end

    assign en_o = en_q;

    // R4: the enable may only move in a cycle where the target was sampled low
    assert_en_move_low_R4: assert property (@(posedge clk) disable iff (rst)
        !$stable(en_q) |-> !$past(tgt_i.lvl));

    // R4: the enable moves only out of the armed state
    assert_en_from_armed_R4: assert property (@(posedge clk) disable iff (rst)
        !$stable(en_q) |-> ($past(state_q) == GS_ARMED));

    // R4: arming follows a rising edge of the free bus clock
    assert_arm_after_rise_R4: assert property (@(posedge clk) disable iff (rst)
        (state_q == GS_ARMED && $past(state_q) == GS_IDLE) |-> $past(arm_i));

    // R5: a request withdrawn while armed is dropped without touching the enable
    assert_drop_stale_R5: assert property (@(posedge clk) disable iff (rst)
        (state_q == GS_ARMED && want_run_i == en_q) |=> (state_q == GS_IDLE && $stable(en_q)));
endmodule

// File: rtl/clkstop_ctrl.sv
module clkstop_ctrl
    import clkstop_pkg::*;
#(
    parameter int N_BUS       = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             host_src_i,
    input  logic             bus_src_i,
    input  logic             host_stop_n_i,
    input  logic             bus_stop_n_i,
    output logic             host_run_o,
    output logic             host_gate_o,
    output logic             bus_run_o,
    output logic [N_BUS-1:0] bus_gate_o
);
    logic [N_GRP-1:0] src_lvl;
    logic [N_GRP-1:0] stop_n;
    logic [N_GRP-1:0] want_run;
    logic [N_GRP-1:0] en;
    edge_t            src_ev [N_GRP];
    logic             bus_rise;

    assign src_lvl[GRP_HOST] = host_src_i;
    assign src_lvl[GRP_BUS]  = bus_src_i;
    assign stop_n[GRP_HOST]  = host_stop_n_i;
    assign stop_n[GRP_BUS]   = bus_stop_n_i;

    for (genvar g = 0; g < N_GRP; g++) begin : g_edge
        clkstop_edge u_edge (
            .clk   (clk),
            .rst   (rst),
            .src_i (src_lvl[g]),
            .ev_o  (src_ev[g])
        );
    end

    assign bus_rise = src_ev[GRP_BUS].rise;

    for (genvar g = 0; g < N_GRP; g++) begin : g_grp
        clkstop_sync #(
            .STAGES  (SYNC_STAGES),
            .RST_VAL (1'b1)
        ) u_sync (
            .clk   (clk),
            .rst   (rst),
            .adv_i (bus_rise),
            .d_i   (stop_n[g]),
            .q_o   (want_run[g])
        );

        clkstop_gate_ctl u_ctl (
            .clk        (clk),
            .rst        (rst),
            .want_run_i (want_run[g]),
            .arm_i      (bus_rise),
            .tgt_i      (src_ev[g]),
            .en_o       (en[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            host_run_o  <= 1'b0;
            host_gate_o <= 1'b0;
            bus_run_o   <= 1'b0;
        end else begin
            host_run_o  <= host_src_i;
            host_gate_o <= host_src_i & en[GRP_HOST];
            bus_run_o   <= bus_src_i;
        end
    end

    for (genvar b = 0; b < N_BUS; b++) begin : g_bus_out
        logic q;
        always_ff @(posedge clk) begin
            if (rst) q <= 1'b0;
            else     q <= bus_src_i & en[GRP_BUS];
        end
        assign bus_gate_o[b] = q;

        // R3: a gated bus pulse lies inside a free bus pulse
        assert_bus_inside_R3: assert property (@(posedge clk) disable iff (rst)
            q |-> bus_run_o);
        // R3: a gated bus pulse begins with the free pulse
        assert_bus_rise_R3: assert property (@(posedge clk) disable iff (rst)
            $rose(q) |-> $rose(bus_run_o));
        // R3: a gated bus pulse ends with the free pulse
        assert_bus_fall_R3: assert property (@(posedge clk) disable iff (rst)
            $fell(q) |-> $fell(bus_run_o));
    end

    // R3: a gated host pulse lies inside a free host pulse
    assert_host_inside_R3: assert property (@(posedge clk) disable iff (rst)
        host_gate_o |-> host_run_o);
    // R3: a gated host pulse begins with the free pulse
    assert_host_rise_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(host_gate_o) |-> $rose(host_run_o));
    // R3: a gated host pulse ends with the free pulse
    assert_host_fall_R3: assert property (@(posedge clk) disable iff (rst)
        $fell(host_gate_o) |-> $fell(host_run_o));
endmodule

// File: tb/test_clkstop_ctrl.sv
module test_clkstop_ctrl;
    localparam int N_BUS = 5;
    localparam int HH    = 2;   // host half period in clk cycles
    localparam int BH    = 6;   // bus half period in clk cycles
    localparam int NV    = 8;

    // {host_stop_n, bus_stop_n, expect host running, expect bus running}
    localparam logic [3:0] VEC [NV] = '{
        4'b1111, 4'b0101, 4'b0000, 4'b1010,
        4'b1111, 4'b0000, 4'b0101, 4'b1111
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic host_src = 1'b0, bus_src = 1'b0;
    logic host_stop_n = 1'b1, bus_stop_n = 1'b1;
    logic host_run_o, host_gate_o, bus_run_o;
    logic [N_BUS-1:0] bus_gate_o;

    int n_checks = 0;
    int n_fail   = 0;
    int hcnt = 0, bcnt = 0;
    int hw_h = 0;
    int hw_b [N_BUS];

    clkstop_ctrl #(.N_BUS(N_BUS), .SYNC_STAGES(2)) i_clkstop_ctrl (
        .clk           (clk),
        .rst           (rst),
        .host_src_i    (host_src),
        .bus_src_i     (bus_src),
        .host_stop_n_i (host_stop_n),
        .bus_stop_n_i  (bus_stop_n),
        .host_run_o    (host_run_o),
        .host_gate_o   (host_gate_o),
        .bus_run_o     (bus_run_o),
        .bus_gate_o    (bus_gate_o)
    );

    always #2 clk = ~clk;

    always @(negedge clk) begin
        if (hcnt == HH - 1) begin hcnt = 0; host_src = ~host_src; end
        else hcnt++;
        if (bcnt == BH - 1) begin bcnt = 0; bus_src = ~bus_src; end
        else bcnt++;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    // R3: width of every gated high pulse
    initial for (int b = 0; b < N_BUS; b++) hw_b[b] = 0;
    always @(negedge clk) begin
        if (!rst) begin
            if (host_gate_o) hw_h++;
            else if (hw_h != 0) begin
                chk(hw_h == HH, "R3 host pulse width", hw_h, HH);
                hw_h = 0;
            end
            for (int b = 0; b < N_BUS; b++) begin
                if (bus_gate_o[b]) hw_b[b]++;
                else if (hw_b[b] != 0) begin
                    chk(hw_b[b] == BH, "R3 bus pulse width", hw_b[b], BH);
                    hw_b[b] = 0;
                end
            end
        end
    end

    task automatic observe(input bit exp_h, input bit exp_b, input int cycles, input string req);
        int bad_h = 0, bad_b = 0, tog_h = 0, tog_b = 0;
        logic ph = host_run_o, pb = bus_run_o;
        repeat (cycles) begin
            @(negedge clk);
            if (host_gate_o !== (exp_h ? host_run_o : 1'b0)) bad_h++;
            if (bus_gate_o !== (exp_b ? {N_BUS{bus_run_o}} : {N_BUS{1'b0}})) bad_b++;
            if (host_run_o != ph) tog_h++;
            if (bus_run_o != pb) tog_b++;
            ph = host_run_o;
            pb = bus_run_o;
        end
        chk(bad_h == 0, {req, " host gated mismatch cycles"}, bad_h, 0);
        chk(bad_b == 0, {req, " bus gated mismatch cycles"}, bad_b, 0);
        chk(tog_h > 0 && tog_b > 0, "R2 free outputs toggle", tog_h * 1000 + tog_b, 1);
    endtask

    // counts free-bus rises until the host gated output first differs in state
    task automatic count_to_switch(input bit stopping, output int rises);
        logic pb = bus_run_o;
        int guard = 0;
        rises = 0;
        forever begin
            @(negedge clk);
            if (bus_run_o && !pb) rises++;
            pb = bus_run_o;
            if (stopping && host_run_o && !host_gate_o) break;
            if (!stopping && host_gate_o) break;
            guard++;
            if (guard > 200) break;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int rises;
        // R6: reset state
        repeat (5) @(negedge clk);
        chk({host_run_o, host_gate_o, bus_run_o, bus_gate_o} == '0, "R6 outputs in reset",
            int'({host_run_o, host_gate_o, bus_run_o, bus_gate_o}), 0);
        rst = 1'b0;
        repeat (60) @(negedge clk);
        observe(1'b1, 1'b1, 24, "R6 startup");

        // R1 R7: table of stop combinations
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            host_stop_n = VEC[i][3];
            bus_stop_n  = VEC[i][2];
            repeat (60) @(negedge clk);
            observe(VEC[i][1], VEC[i][0], 24, "R1 R7 vector");
        end

        // R5: host stop present at exactly one bus rise is dropped
        @(posedge bus_src); #1 host_stop_n = 1'b0;
        @(posedge bus_src); #1 host_stop_n = 1'b1;
        observe(1'b1, 1'b1, 72, "R5 host drop");

        // R5: bus stop present at exactly one bus rise is dropped
        @(posedge bus_src); #1 bus_stop_n = 1'b0;
        @(posedge bus_src); #1 bus_stop_n = 1'b1;
        observe(1'b1, 1'b1, 72, "R5 bus drop");

        // R4: handshake depth on a stop
        @(posedge bus_src); #1 host_stop_n = 1'b0;
        count_to_switch(1'b1, rises);
        chk(rises == 3, "R4 bus rises before host stop", rises, 3);
        repeat (30) @(negedge clk);
        observe(1'b0, 1'b1, 24, "R1 host stopped");

        // R4: handshake depth on a restart
        @(posedge bus_src); #1 host_stop_n = 1'b1;
        count_to_switch(1'b0, rises);
        chk(rises == 3, "R4 bus rises before host restart", rises, 3);
        repeat (30) @(negedge clk);
        observe(1'b1, 1'b1, 24, "R1 host restarted");

        // R6: reset in mid-run clears all outputs
        @(negedge clk) rst = 1'b1;
        repeat (3) @(negedge clk);
        chk({host_run_o, host_gate_o, bus_run_o, bus_gate_o} == '0, "R6 outputs in second reset",
            int'({host_run_o, host_gate_o, bus_run_o, bus_gate_o}), 0);
        rst = 1'b0;
        hw_h = 0;
        for (int b = 0; b < N_BUS; b++) hw_b[b] = 0;
        repeat (60) @(negedge clk);
        observe(1'b1, 1'b1, 24, "R6 restart");

        finish_run();
    end
endmodule